// File: doc/BRIEF.md
# Configurable Partition Transformation Decoder

This block sits between the instruction bus and the fetch stage. It turns encoded 32-bit words back into the original instructions. Inside frequently executed basic blocks, each word was stored in a form that flips fewer bus lines than the original. The word is split into six 5-bit fields, and two bits stay unencoded. Each field is restored from the current encoded field and a history field taken from the previous word. The history is either the previous restored field or the previous encoded field. A bitwise two-input Boolean function combines the two.

The block supports 32 restoring functions: sixteen two-input truth tables for each of the two history kinds. A hot spot uses only four of them. Those four 5-bit function codes are held in selector registers. Every encoded instruction carries one 2-bit selector index per field, taken from a transformation table. A basic-block table holds block start addresses and the first table entry of each block. When the fetch address hits a block start, that word passes through unchanged and decoding begins with the next word. Decoding ends after the entry whose end flag is set. Outside a block, words pass through. The tables and selectors are loaded through a simple write port.

Top module: `xform_decoder`

## Requirements
- R1: After reset no block is active and no block-table entry is valid, so every fetched word appears unchanged on `instr_o`, even at an address that is later used as a block start.
- R2: Bits 30 and 6 of `instr_o` always equal the same bits of `code_i`.
- R3: A fetch whose `pc_i` equals the start address of a valid block-table entry outputs `code_i` unchanged. It loads that entry's pointer, and decoding then applies to the following fetch.
- R4: The fields, least significant bit first, are: field 0 = bits 26,27,28,29,31; field 1 = bits 21..25; field 2 = bits 16..20; field 3 = bits 11..15; field 4 = bits 5,7,8,9,10; field 5 = bits 0..4. In a table entry, the selector index for field j sits at bits [2j+1:2j], and bit 12 is the end flag.
- R5: For a function code with bit 4 = 0, each restored bit equals code bit [{h,c}]. Here h is the previous restored bit at the same position and c is the current encoded bit.
- R6: For a function code with bit 4 = 1, the same rule applies, but h is the previous encoded bit at that position.
- R7: The 2-bit index of a field picks one of four selector registers, and that register gives the field's 5-bit function code. On a write, `cfg_sel_i` picks the target: 0 = block start address (also marks the entry valid), 1 = block pointer, 2 = table entry, 3 = selector register. `cfg_addr_i` picks the entry.
- R8: After a decoded fetch whose table entry has the end flag set, the following fetches pass through unchanged until a block start is hit again.
- R9: Cycles with `fetch_valid_i` low do not advance the pointer or change the history. A stall inside a block leaves decoding of the next word unaffected.
- R10: Hitting a block start while a block is active restarts decoding from that entry's pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid_i | input | 1 | An encoded word is present this cycle |
| pc_i | input | 32 | Fetch address of the word |
| code_i | input | 32 | Encoded word from the bus |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_sel_i | input | 2 | Write target (see R7) |
| cfg_addr_i | input | 4 | Entry index of the write |
| cfg_data_i | input | 32 | Write data |
| instr_o | output | 32 | Restored instruction, same cycle as the fetch |

## Verification
The hardest case to reach is one where every one of the 32 function codes meets all four combinations of history bit and current bit, in both history kinds. Both kinds must also be active in different fields of one word. The bench sweeps each function code through every selector slot, rotates the per-field indices on every entry, and feeds pseudo-random words. Every history combination therefore occurs across the six fields. Stalls with different bus values are inserted mid-block, and a block start is refetched before the end flag is reached.

// File: rtl/xdec_pkg.sv
package xdec_pkg;
    localparam int IW    = 32;
    localparam int PW    = 5;
    localparam int NPART = 6;
    localparam int FW    = 5;

    // bit position of element i of field p (fixed instruction layout)
    function automatic int part_bit(input int p, input int i);
        case (p)
            0:       return (i == 4) ? 31 : 26 + i;
            1:       return 21 + i;
            2:       return 16 + i;
            3:       return 11 + i;
            4:       return (i == 0) ? 5 : 6 + i;
            default: return i;
        endcase
    endfunction
endpackage

// File: rtl/xdec_field_ulu.sv
module xdec_field_ulu #(
    parameter int PW = 5,
    parameter int FW = 5
) (
    input  logic [FW-1:0] fcode,
    input  logic [PW-1:0] hist_orig,
    input  logic [PW-1:0] hist_code,
    input  logic [PW-1:0] cur,
    output logic [PW-1:0] restored
);
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            logic h;
            h = fcode[FW-1] ? hist_code[i] : hist_orig[i];
            restored[i] = fcode[{h, cur[i]}];
        end
    end
endmodule

// File: rtl/xdec_block_match.sv
module xdec_block_match #(
    parameter int N  = 4,
    parameter int AW = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [AW-1:0]        pc,
    input  logic [N-1:0]         vld,
    input  logic [N-1:0][AW-1:0] start_pc,
    output logic                 hit,
    output logic [IW-1:0]        idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int e = N - 1; e >= 0; e--) begin
            if (vld[e] && start_pc[e] == pc) begin
                hit = 1'b1;
                idx = IW'(e);
            end
        end
    end
endmodule

// File: rtl/xform_decoder.sv
module xform_decoder #(
    parameter int BB_N = 4,
    parameter int TT_N = 16,
    parameter int NSEL = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fetch_valid_i,
    input  logic [31:0] pc_i,
    input  logic [31:0] code_i,
    input  logic        cfg_we_i,
    input  logic [1:0]  cfg_sel_i,
    input  logic [3:0]  cfg_addr_i,
    input  logic [31:0] cfg_data_i,
    output logic [31:0] instr_o
);
    import xdec_pkg::*;

    localparam int BBW   = (BB_N > 1) ? $clog2(BB_N) : 1;
    localparam int TTW   = $clog2(TT_N);
    localparam int SELW  = $clog2(NSEL);
    localparam int TTE_W = NPART * SELW + 1;

    typedef struct packed {
        logic                         active;
        logic [TTW-1:0]               ptr;
        logic [IW-1:0]                prev_o;
        logic [IW-1:0]                prev_c;
        logic [BB_N-1:0]              bb_vld;
        logic [BB_N-1:0][IW-1:0]      bb_pc;
        logic [BB_N-1:0][TTW-1:0]     bb_ptr;
        logic [TT_N-1:0][TTE_W-1:0]   tt;
        logic [NSEL-1:0][FW-1:0]      fsel;
    } state_t;

    state_t s_d, s_q;

    logic             hit;
    logic [BBW-1:0]   hit_idx;
    logic [TTE_W-1:0] tte;
    logic             end_bit;
    logic             decode_en;
    logic [IW-1:0]    dec_word;
    logic             act_q;
    logic [TTW-1:0]   ptr_q;
    logic [IW-1:0]    prevc_q;

    xdec_block_match #(.N(BB_N), .AW(IW)) u_match (
        .pc       (pc_i),
        .vld      (s_q.bb_vld),
        .start_pc (s_q.bb_pc),
        .hit      (hit),
        .idx      (hit_idx)
    );

    assign tte     = s_q.tt[s_q.ptr];
    assign end_bit = tte[TTE_W-1];

    logic [NPART-1:0][PW-1:0] f_cur, f_ho, f_hc, f_out;
    logic [NPART-1:0][FW-1:0] f_code;

    for (genvar p = 0; p < NPART; p++) begin : g_part
        for (genvar i = 0; i < PW; i++) begin : g_bit
            localparam int B = part_bit(p, i);
            assign f_cur[p][i] = code_i[B];
            assign f_ho[p][i]  = s_q.prev_o[B];
            assign f_hc[p][i]  = s_q.prev_c[B];
        end
        assign f_code[p] = s_q.fsel[tte[p*SELW +: SELW]];
        xdec_field_ulu #(.PW(PW), .FW(FW)) u_ulu (
            .fcode     (f_code[p]),
            .hist_orig (f_ho[p]),
            .hist_code (f_hc[p]),
            .cur       (f_cur[p]),
            .restored  (f_out[p])
        );
    end

    always_comb begin
        dec_word     = code_i;
        for (int p = 0; p < NPART; p++) begin
            for (int i = 0; i < PW; i++) begin
                dec_word[part_bit(p, i)] = f_out[p][i];
            end
        end
    end

    assign decode_en = s_q.active && !hit;
    assign instr_o   = decode_en ? dec_word : code_i;

    always_comb begin
        s_d = s_q;
        if (fetch_valid_i) begin
            s_d.prev_o = instr_o;
            s_d.prev_c = code_i;
            if (hit) begin
                s_d.active = 1'b1;
                s_d.ptr    = s_q.bb_ptr[hit_idx];
            end else if (s_q.active) begin
                s_d.ptr = s_q.ptr + 1'b1;
                if (end_bit) s_d.active = 1'b0;
            end
        end
        if (cfg_we_i) begin
            case (cfg_sel_i)
                2'd0: begin
                    s_d.bb_pc[cfg_addr_i[BBW-1:0]]  = cfg_data_i;
                    s_d.bb_vld[cfg_addr_i[BBW-1:0]] = 1'b1;
                end
                2'd1: s_d.bb_ptr[cfg_addr_i[BBW-1:0]] = cfg_data_i[TTW-1:0];
                2'd2: s_d.tt[cfg_addr_i[TTW-1:0]]     = cfg_data_i[TTE_W-1:0];
                default: s_d.fsel[cfg_addr_i[SELW-1:0]] = cfg_data_i[FW-1:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act_q   = s_q.active;
    assign ptr_q   = s_q.ptr;
    assign prevc_q = s_q.prev_c;
endmodule

// File: rtl/xdec_checker.sv
module xdec_checker #(
    parameter int TTW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           fetch_valid_i,
    input logic [31:0]    code_i,
    input logic [31:0]    instr_o,
    input logic           hit,
    input logic           end_bit,
    input logic           act_q,
    input logic [TTW-1:0] ptr_q,
    input logic [31:0]    prevc_q
);
    p_raw_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        instr_o[30] == code_i[30] && instr_o[6] == code_i[6]);

    p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q |-> instr_o == code_i);

    p_start_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_i && hit |-> instr_o == code_i);

    p_start_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_i && hit |=> act_q);

    p_end_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_i && act_q && !hit && end_bit |=> !act_q);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid_i |=> $stable(ptr_q) && $stable(act_q) && $stable(prevc_q));

    p_hist_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_i |=> prevc_q == $past(code_i));
endmodule

bind xform_decoder xdec_checker #(.TTW(TTW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_valid_i (fetch_valid_i),
    .code_i        (code_i),
    .instr_o       (instr_o),
    .hit           (hit),
    .end_bit       (end_bit),
    .act_q         (act_q),
    .ptr_q         (ptr_q),
    .prevc_q       (prevc_q)
);

// File: tb/xform_decoder_test.sv
module xform_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic [31:0] code_i = '0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_sel_i = '0;
    logic [3:0]  cfg_addr_i = '0;
    logic [31:0] cfg_data_i = '0;
    logic [31:0] instr_o;

    int errors = 0;
    int checks = 0;

    // bench model state
    logic        m_act = 1'b0;
    logic [3:0]  m_ptr = '0;
    logic [31:0] m_po = '0, m_pc = '0;
    logic [3:0]  m_bbv = '0;
    logic [31:0] m_bbpc [4];
    logic [3:0]  m_bbptr [4];
    logic [12:0] m_tt [16];
    logic [4:0]  m_fs [4];
    logic [31:0] rng = 32'h1234_5678;

    always #5 clk = ~clk;

    xform_decoder uut (.*);

    function automatic int bpos(input int p, input int i);
        if (p == 0) return (i == 4) ? 31 : 26 + i;
        if (p == 4) return (i == 0) ? 5 : 6 + i;
        if (p == 5) return i;
        return 21 - 5 * (p - 1) + i;
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input int addr, input logic [31:0] data);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_addr_i = 4'(addr); cfg_data_i = data;
        @(posedge clk); #1;
        cfg_we_i = 1'b0;
        if (sel == 0) begin m_bbpc[addr[1:0]] = data; m_bbv[addr[1:0]] = 1'b1; end
        else if (sel == 1) m_bbptr[addr[1:0]] = data[3:0];
        else if (sel == 2) m_tt[addr[3:0]] = data[12:0];
        else m_fs[addr[1:0]] = data[4:0];
    endtask

    task automatic stall(input logic [31:0] junk);
        @(negedge clk);
        fetch_valid_i = 1'b0; code_i = junk; pc_i = 32'hFFFF_0000;
        @(posedge clk); #1;
    endtask

    task automatic fetch(input string req, input logic [31:0] pc, input logic [31:0] code);
        logic        hit;
        int          hi;
        logic [31:0] exp;
        logic [12:0] e;
        hit = 1'b0; hi = 0;
        for (int k = 3; k >= 0; k--)
            if (m_bbv[k] && m_bbpc[k] == pc) begin hit = 1'b1; hi = k; end
        exp = code;
        if (m_act && !hit) begin
            e = m_tt[m_ptr];
            for (int p = 0; p < 6; p++) begin
                logic [4:0] f;
                f = m_fs[e[2*p +: 2]];
                for (int i = 0; i < 5; i++) begin
                    int b;
                    logic h;
                    b = bpos(p, i);
                    h = f[4] ? m_pc[b] : m_po[b];
                    exp[b] = f[{h, code[b]}];
                end
            end
        end
        @(negedge clk);
        fetch_valid_i = 1'b1; pc_i = pc; code_i = code;
        #2;
        check(req, instr_o, exp);
        if (instr_o[30] !== code[30] || instr_o[6] !== code[6]) begin
            checks++; errors++;
            $display("FAIL R2 actual=%h expected raw bits of %h", instr_o, code);
        end else checks++;
        @(posedge clk); #1;
        fetch_valid_i = 1'b0;
        m_po = exp; m_pc = code;
        if (hit) begin m_act = 1'b1; m_ptr = m_bbptr[hi]; end
        else if (m_act) begin
            if (m_tt[m_ptr][12]) m_act = 1'b0;
            m_ptr = m_ptr + 1'b1;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: nothing configured, block start address not yet valid
        fetch("R1 reset pass", 32'h100, 32'hDEAD_BEEF);
        fetch("R1 reset pass", 32'h104, 32'h0F0F_A5A5);

        wr(2'd0, 0, 32'h100);
        wr(2'd1, 0, 32'd0);
        wr(2'd0, 1, 32'h200);
        wr(2'd1, 1, 32'd8);

        // R4 R5 R6 R7: sweep every function code through every selector slot
        for (int f = 0; f < 32; f++) begin
            for (int k = 0; k < 4; k++) wr(2'd3, k, 32'((f + 9 * k) % 32));
            for (int e = 0; e < 4; e++) begin
                logic [12:0] ent;
                ent = '0;
                for (int p = 0; p < 6; p++) ent[2*p +: 2] = 2'((p + e + f) % 4);
                ent[12] = (e == 3);
                wr(2'd2, e, 32'(ent));
            end
            rng = next_rng(rng);
            fetch("R3 block start pass", 32'h100, rng);
            for (int w = 0; w < 4; w++) begin
                rng = next_rng(rng);
                if (f[0] && w == 2) stall(~rng);   // R9 stall mid-block
                fetch("R4 R5 R6 R7 R9 decode", 32'h104 + 32'(4 * w), rng);
            end
            rng = next_rng(rng);
            fetch("R8 pass after end", 32'h300, rng);
        end

        // R10: restart of a block while it is active
        for (int e = 8; e < 13; e++) begin
            logic [12:0] ent;
            ent = '0;
            for (int p = 0; p < 6; p++) ent[2*p +: 2] = 2'((3 * p + e) % 4);
            ent[12] = (e == 11);
            wr(2'd2, e, 32'(ent));
        end
        wr(2'd3, 0, 32'h11); wr(2'd3, 1, 32'h06);
        wr(2'd3, 2, 32'h1A); wr(2'd3, 3, 32'h09);
        rng = next_rng(rng); fetch("R3 start", 32'h200, rng);
        rng = next_rng(rng); fetch("R10 decode", 32'h204, rng);
        rng = next_rng(rng); fetch("R10 decode", 32'h208, rng);
        rng = next_rng(rng); fetch("R10 restart pass", 32'h200, rng);
        for (int w = 0; w < 5; w++) begin
            rng = next_rng(rng);
            fetch("R10 R8 decode after restart", 32'h204 + 32'(4 * w), rng);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule